// File: doc/BRIEF.md
# Burst-Packing Accelerator Memory Buffer

This block sits between a 128-bit Wishbone master port and a streaming accelerator with a parameterised number of 32-bit input ports and 32-bit output ports. Once a controller has loaded a source base and a destination base, the block keeps prefetching input data in 16-byte, four-word beats from consecutive addresses. Each beat goes into an input FIFO. A read-in command hands the accelerator one fresh word per input port. A write-out command samples the accelerator outputs, queues them in an output FIFO, and writes them back to memory as full four-word beats.

A flush command drains whatever is left in the output FIFO as one partial beat, with byte selects enabled only for the valid words. The block keeps and advances both addresses by itself. While any command is still being carried out, it raises stall. The controller that sequences the loop and the accelerator itself sit outside the block.

Top module: `burst_pack_buf`

## Requirements
- R1: After reset, stall is low and no bus cycle starts until an address load has been applied.
- R2: Reads use consecutive addresses, starting at the loaded source base and advancing 16 bytes per beat, with all sixteen byte selects set. Bus data bits [32j+31:32j] hold the word at beat address + 4j.
- R3: When a read-in completes, input port i (acc_in bits [32i+31:32i]) holds the i-th next word of the source stream, and exactly one word per input port is consumed.
- R4: A read-in keeps stall high until the input FIFO holds at least one word per input port.
- R5: A write-out samples acc_out in its command cycle. Output port k becomes the k-th word of its group in the destination stream, so later changes to acc_out have no effect.
- R6: Once four or more output words are queued, they are written as one beat with all byte selects set. Destination addresses start at the loaded base and advance 16 bytes per beat.
- R7: A flush writes the remaining c (1 to 3) words as one beat with byte selects covering the low 4c bytes only. It holds stall high until the output FIFO is empty.
- R8: A command raised while stall is high is ignored.
- R9: Address, direction and byte selects stay constant from the start of a bus cycle until its acknowledge.
- R10: A later address load discards prefetched input and restarts both streams at the new bases.
- R11: A read is issued only when the input FIFO has room for four words, so long idle prefetching loses and reorders no input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load source and destination bases |
| in_base | input | ADDR_W | Source stream byte address |
| out_base | input | ADDR_W | Destination stream byte address |
| read_in | input | 1 | Read-in command |
| write_out | input | 1 | Write-out command |
| flush | input | 1 | Drain the output FIFO, partial beat allowed |
| acc_out | input | N_OUT*32 | Accelerator output words |
| acc_in | output | N_IN*32 | Accelerator input words |
| stall | output | 1 | Command in progress; new commands ignored |
| wbm_cyc | output | 1 | Bus cycle |
| wbm_stb | output | 1 | Bus strobe |
| wbm_we | output | 1 | Bus write enable |
| wbm_adr | output | ADDR_W | Bus byte address |
| wbm_dat_o | output | 128 | Bus write data |
| wbm_sel | output | 16 | Bus byte selects |
| wbm_dat_i | input | 128 | Bus read data |
| wbm_ack | input | 1 | Bus acknowledge |

## Verification
Two pairs of operations can land on the same clock edge. On the output FIFO, a pending write-out push can coincide with the acknowledge that pops a burst. On the input FIFO, a read-in pop can coincide with a read acknowledge that pushes a beat. The bench provokes both by interleaving write-out and read-in commands while it sweeps the responder's acknowledge latency from zero to three cycles, which moves the acknowledges across the command timing. The result is judged from the end state: the destination memory image has to match the expected word sequence, and every read-in has to return the next words of the source stream.

// File: rtl/burst_pack_pkg.sv
package burst_pack_pkg;
   localparam int WORD_W     = 32;
   localparam int BEAT_WORDS = 4;
   localparam int BEAT_BITS  = WORD_W * BEAT_WORDS;
   localparam int BEAT_BYTES = BEAT_BITS / 8;
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bpb_word_fifo.sv
module bpb_word_fifo
   import burst_pack_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int PUSH_MAX = 4,
   parameter int POP_MAX  = 4
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               clr,
   input  logic [$clog2(PUSH_MAX+1)-1:0]      push_n,
   input  logic [PUSH_MAX*WORD_W-1:0]         din,
   input  logic [$clog2(POP_MAX+1)-1:0]       pop_n,
   output logic [POP_MAX*WORD_W-1:0]          dout,
   output logic [$clog2(DEPTH+1)-1:0]         level
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH+1);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("bpb_word_fifo: DEPTH must be a power of two and at least 4");
   end
   if (PUSH_MAX > DEPTH || POP_MAX > DEPTH) begin : g_bad_ports
      $error("bpb_word_fifo: push or pop width exceeds DEPTH");
   end

   word_t            mem [DEPTH];
   logic [AW-1:0]    wp, rp;

   always_ff @(posedge clk) begin
      for (int i = 0; i < PUSH_MAX; i++) begin
         if (i < int'(push_n)) mem[wp + AW'(i)] <= din[i*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         wp    <= wp + AW'(push_n);
         rp    <= rp + AW'(pop_n);
         level <= level + LW'(push_n) - LW'(pop_n);
      end
   end

   for (genvar g = 0; g < POP_MAX; g++) begin : g_rd
      assign dout[g*WORD_W +: WORD_W] = mem[rp + AW'(g)];
   end
endmodule

// File: rtl/bpb_bus_port.sv
module bpb_bus_port
   import burst_pack_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ld_apply,
   input  logic [ADDR_W-1:0]     in_base,
   input  logic [ADDR_W-1:0]     out_base,
   input  logic                  rd_req,
   input  logic                  wr_req,
   input  logic [2:0]            wr_cnt,
   input  logic [BEAT_BITS-1:0]  wr_words,
   input  logic                  ack,
   output logic                  cyc,
   output logic                  stb,
   output logic                  we,
   output logic [ADDR_W-1:0]     adr,
   output logic [BEAT_BITS-1:0]  dat_o,
   output logic [BEAT_BYTES-1:0] sel,
   output logic                  push_rd,
   output logic [2:0]            pop_wr,
   output logic                  busy
);
   logic              busy_q, we_q;
   logic [2:0]        cnt_q;
   logic [ADDR_W-1:0] rd_adr, wr_adr;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         we_q   <= 1'b0;
         cnt_q  <= '0;
         rd_adr <= '0;
         wr_adr <= '0;
      end else begin
         if (ld_apply) begin
            rd_adr <= in_base;
            wr_adr <= out_base;
         end
         if (!busy_q) begin
            if (!ld_apply && (rd_req || wr_req)) begin
               busy_q <= 1'b1;
               we_q   <= wr_req;
               cnt_q  <= wr_req ? wr_cnt : 3'(BEAT_WORDS);
            end
         end else if (ack) begin
            busy_q <= 1'b0;
            if (we_q) wr_adr <= wr_adr + ADDR_W'(BEAT_BYTES);
            else      rd_adr <= rd_adr + ADDR_W'(BEAT_BYTES);
         end
      end
   end

   for (genvar k = 0; k < BEAT_WORDS; k++) begin : g_lane
      logic lane_on;
      assign lane_on                    = !we_q || (3'(k) < cnt_q);
      assign sel[k*4 +: 4]              = {4{lane_on}};
      assign dat_o[k*WORD_W +: WORD_W]  = (we_q && lane_on) ? wr_words[k*WORD_W +: WORD_W] : '0;
   end

   assign cyc     = busy_q;
   assign stb     = busy_q;
   assign we      = we_q;
   assign adr     = we_q ? wr_adr : rd_adr;
   assign push_rd = busy_q && ack && !we_q;
   assign pop_wr  = (busy_q && ack && we_q) ? cnt_q : 3'd0;
   assign busy    = busy_q;
endmodule

// File: rtl/burst_pack_buf.sv
module burst_pack_buf
   import burst_pack_pkg::*;
#(
   parameter int N_IN        = 3,
   parameter int N_OUT       = 2,
   parameter int IFIFO_DEPTH = 8,
   parameter int OFIFO_DEPTH = 8,
   parameter int ADDR_W      = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     addr_load,
   input  logic [ADDR_W-1:0]        in_base,
   input  logic [ADDR_W-1:0]        out_base,
   input  logic                     read_in,
   input  logic                     write_out,
   input  logic                     flush,
   input  logic [N_OUT*WORD_W-1:0]  acc_out,
   output logic [N_IN*WORD_W-1:0]   acc_in,
   output logic                     stall,
   output logic                     wbm_cyc,
   output logic                     wbm_stb,
   output logic                     wbm_we,
   output logic [ADDR_W-1:0]        wbm_adr,
   output logic [BEAT_BITS-1:0]     wbm_dat_o,
   output logic [BEAT_BYTES-1:0]    wbm_sel,
   input  logic [BEAT_BITS-1:0]     wbm_dat_i,
   input  logic                     wbm_ack
);
   localparam int ILW = $clog2(IFIFO_DEPTH+1);
   localparam int OLW = $clog2(OFIFO_DEPTH+1);
   localparam int INW = $clog2(N_IN+1);
   localparam int ONW = $clog2(N_OUT+1);
   localparam int BNW = $clog2(BEAT_WORDS+1);

   if (IFIFO_DEPTH < N_IN + BEAT_WORDS - 1) begin : g_bad_ififo
      $error("burst_pack_buf: IFIFO_DEPTH must be at least N_IN+3");
   end
   if (OFIFO_DEPTH < N_OUT + BEAT_WORDS - 1) begin : g_bad_ofifo
      $error("burst_pack_buf: OFIFO_DEPTH must be at least N_OUT+3");
   end
   if (N_IN < 1 || N_OUT < 1 || ADDR_W < 5) begin : g_bad_misc
      $error("burst_pack_buf: port counts or address width out of range");
   end

   logic                     ld_pend, run, rd_pend, wr_pend, fl_pend;
   logic [ADDR_W-1:0]        lin, lout;
   logic [N_OUT*WORD_W-1:0]  obuf;
   logic [N_IN*WORD_W-1:0]   acc_in_q, idout;
   logic [BEAT_BITS-1:0]     odout;
   logic [ILW-1:0]           ilevel;
   logic [OLW-1:0]           olevel;
   logic                     busy, push_rd, accept, ld_apply, rd_go, wr_go, fl_done;
   logic                     rd_req, wr_req, wr_full;
   logic [2:0]               pop_wr, wr_cnt;

   assign stall    = ld_pend | rd_pend | wr_pend | fl_pend;
   assign accept   = !stall;
   assign ld_apply = ld_pend && !busy;
   assign rd_go    = rd_pend && !ld_pend && (int'(ilevel) >= N_IN);
   assign wr_go    = wr_pend && (int'(olevel) + N_OUT <= OFIFO_DEPTH);
   assign wr_full  = int'(olevel) >= BEAT_WORDS;
   assign wr_req   = wr_full || (fl_pend && !wr_pend && olevel != '0);
   assign wr_cnt   = wr_full ? 3'(BEAT_WORDS) : 3'(olevel);
   assign rd_req   = run && (int'(ilevel) + BEAT_WORDS <= IFIFO_DEPTH);
   assign fl_done  = fl_pend && !wr_pend && olevel == '0 && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         ld_pend  <= 1'b0;
         run      <= 1'b0;
         rd_pend  <= 1'b0;
         wr_pend  <= 1'b0;
         fl_pend  <= 1'b0;
         lin      <= '0;
         lout     <= '0;
         obuf     <= '0;
         acc_in_q <= '0;
      end else begin
         if (accept && addr_load) begin
            ld_pend <= 1'b1;
            lin     <= in_base;
            lout    <= out_base;
         end else if (ld_apply) begin
            ld_pend <= 1'b0;
            run     <= 1'b1;
         end
         if (accept && read_in)        rd_pend <= 1'b1;
         else if (rd_go)               rd_pend <= 1'b0;
         if (accept && write_out) begin
            wr_pend <= 1'b1;
            obuf    <= acc_out;
         end else if (wr_go)           wr_pend <= 1'b0;
         if (accept && flush)          fl_pend <= 1'b1;
         else if (fl_done)             fl_pend <= 1'b0;
         if (rd_go)                    acc_in_q <= idout;
      end
   end

   assign acc_in = acc_in_q;

   bpb_word_fifo #(.DEPTH(IFIFO_DEPTH), .PUSH_MAX(BEAT_WORDS), .POP_MAX(N_IN)) u_ififo (
      .clk(clk), .rst(rst), .clr(ld_apply),
      .push_n(push_rd ? BNW'(BEAT_WORDS) : BNW'(0)),
      .din(wbm_dat_i),
      .pop_n(rd_go ? INW'(N_IN) : INW'(0)),
      .dout(idout), .level(ilevel)
   );

   bpb_word_fifo #(.DEPTH(OFIFO_DEPTH), .PUSH_MAX(N_OUT), .POP_MAX(BEAT_WORDS)) u_ofifo (
      .clk(clk), .rst(rst), .clr(1'b0),
      .push_n(wr_go ? ONW'(N_OUT) : ONW'(0)),
      .din(obuf),
      .pop_n(pop_wr),
      .dout(odout), .level(olevel)
   );

   bpb_bus_port #(.ADDR_W(ADDR_W)) u_bus (
      .clk(clk), .rst(rst), .ld_apply(ld_apply),
      .in_base(lin), .out_base(lout),
      .rd_req(rd_req), .wr_req(wr_req), .wr_cnt(wr_cnt), .wr_words(odout),
      .ack(wbm_ack),
      .cyc(wbm_cyc), .stb(wbm_stb), .we(wbm_we), .adr(wbm_adr),
      .dat_o(wbm_dat_o), .sel(wbm_sel),
      .push_rd(push_rd), .pop_wr(pop_wr), .busy(busy)
   );
endmodule

// File: rtl/burst_pack_buf_chk.sv
module burst_pack_buf_chk #(
   parameter int IFIFO_DEPTH = 8,
   parameter int OFIFO_DEPTH = 8,
   parameter int ADDR_W      = 32
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           run,
   input logic                           cyc,
   input logic                           we,
   input logic                           ack,
   input logic [ADDR_W-1:0]              adr,
   input logic [15:0]                    sel,
   input logic [$clog2(IFIFO_DEPTH+1)-1:0] ilevel,
   input logic [$clog2(OFIFO_DEPTH+1)-1:0] olevel
);
   p_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !run |-> !cyc);

   p_read_sel_r2: assert property (@(posedge clk) disable iff (rst)
      (cyc && !we) |-> sel == 16'hFFFF);

   p_align_r6: assert property (@(posedge clk) disable iff (rst)
      cyc |-> adr[3:0] == 4'h0);

   p_write_sel_r7: assert property (@(posedge clk) disable iff (rst)
      (cyc && we) |-> (sel == 16'h000F || sel == 16'h00FF ||
                       sel == 16'h0FFF || sel == 16'hFFFF));

   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (cyc && !ack) |=> (cyc && $stable(adr) && $stable(we) && $stable(sel)));

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
      (cyc && !we) |-> (int'(ilevel) + 4 <= IFIFO_DEPTH));

   p_ofifo_bound_r6: assert property (@(posedge clk) disable iff (rst)
      int'(olevel) <= OFIFO_DEPTH);
endmodule

bind burst_pack_buf burst_pack_buf_chk #(
   .IFIFO_DEPTH(IFIFO_DEPTH), .OFIFO_DEPTH(OFIFO_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst(rst), .run(run), .cyc(wbm_cyc), .we(wbm_we), .ack(wbm_ack),
   .adr(wbm_adr), .sel(wbm_sel), .ilevel(ilevel), .olevel(olevel)
);

// File: tb/burst_pack_buf_bench.sv
module burst_pack_buf_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N_IN  = 3;
   localparam int N_OUT = 2;
   localparam logic [31:0] IN1  = 32'h0000_1000;
   localparam logic [31:0] OUT1 = 32'h0000_8000;
   localparam logic [31:0] IN2  = 32'h0000_3000;
   localparam logic [31:0] OUT2 = 32'h0000_8400;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic addr_load = 0, read_in = 0, write_out = 0, flush = 0;
   logic [31:0] in_base = '0, out_base = '0;
   logic [N_OUT*32-1:0] acc_out = '0;
   logic [N_IN*32-1:0]  acc_in;
   logic stall, cyc, stb, we, ack;
   logic [31:0]  adr;
   logic [127:0] dat_o, dat_i;
   logic [15:0]  sel;

   int n_chk = 0, n_fail = 0;
   int ack_dly = 0, wcnt = 0, hold_err = 0, radr_err = 0, wlog_n = 0;
   int rd_idx = 0, wk = 0;
   bit in_req = 0, done = 0;
   logic [31:0] req_adr, exp_radr, cur_in;
   logic        req_we;
   logic [31:0] wmem [512];
   logic [15:0] wsel_log [64];
   logic [31:0] wadr_log [64];

   burst_pack_buf u_burst_pack_buf (
      .clk(clk), .rst(rst), .addr_load(addr_load), .in_base(in_base), .out_base(out_base),
      .read_in(read_in), .write_out(write_out), .flush(flush), .acc_out(acc_out),
      .acc_in(acc_in), .stall(stall), .wbm_cyc(cyc), .wbm_stb(stb), .wbm_we(we),
      .wbm_adr(adr), .wbm_dat_o(dat_o), .wbm_sel(sel), .wbm_dat_i(dat_i), .wbm_ack(ack)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] gen(input logic [31:0] a);
      return 32'hA500_0000 ^ a;
   endfunction

   function automatic logic [31:0] out_val(input int k);
      return 32'hC000_0000 + 32'(k);
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory responder
   initial begin
      ack = 1'b0;
      dat_i = '0;
      for (int i = 0; i < 512; i++) wmem[i] = '0;
      forever begin
         @(negedge clk);
         if (ack) begin
            ack = 1'b0;
            in_req = 0;
         end else if (cyc) begin
            if (!in_req) begin
               in_req = 1; req_adr = adr; req_we = we; wcnt = 0;
            end else if (adr !== req_adr || we !== req_we) hold_err++;
            if (wcnt >= ack_dly) begin
               ack = 1'b1;
               if (we) begin
                  for (int j = 0; j < 4; j++)
                     if (sel[4*j]) wmem[(((adr - OUT1) >> 2) + 32'(j)) & 32'd511] = dat_o[32*j +: 32];
                  if (wlog_n < 64) begin
                     wsel_log[wlog_n] = sel; wadr_log[wlog_n] = adr; wlog_n++;
                  end
               end else begin
                  if (adr !== exp_radr) radr_err++;
                  exp_radr = exp_radr + 32'd16;
                  for (int j = 0; j < 4; j++) dat_i[32*j +: 32] = gen(adr + 32'(4*j));
               end
            end else wcnt++;
         end
      end
   end

   task automatic wait_free();
      while (stall) @(negedge clk);
   endtask

   task automatic do_load(input logic [31:0] ib, input logic [31:0] ob);
      wait_free();
      in_base = ib; out_base = ob; addr_load = 1;
      @(negedge clk);
      addr_load = 0;
      wait_free();
      exp_radr = ib; cur_in = ib; rd_idx = 0;
   endtask

   task automatic do_read_in(input string tag);
      wait_free();
      read_in = 1;
      @(negedge clk);
      read_in = 0;
      wait_free();
      for (int i = 0; i < N_IN; i++)
         chk(tag, acc_in[32*i +: 32], gen(cur_in + 32'(4*(rd_idx + i))));
      rd_idx += N_IN;
   endtask

   task automatic do_write_out();
      wait_free();
      for (int i = 0; i < N_OUT; i++) acc_out[32*i +: 32] = out_val(wk + i);
      write_out = 1;
      @(negedge clk);
      write_out = 0;
      acc_out = '1;
      wk += N_OUT;
      wait_free();
   endtask

   task automatic do_flush();
      wait_free();
      flush = 1;
      @(negedge clk);
      flush = 0;
      wait_free();
   endtask

   task automatic t_reset();
      repeat (8) @(negedge clk);
      chk("R1 stall after reset", stall, 0);
      chk("R1 no bus cycle before load", cyc, 0);
   endtask

   task automatic t_read_start();
      ack_dly = 4;
      do_load(IN1, OUT1);
      read_in = 1;
      @(negedge clk);
      read_in = 0;
      chk("R4 stall while input FIFO short", stall, 1);
      read_in = 1;   // R8: raised while stall is high
      @(negedge clk);
      read_in = 0;
      chk("R4 stall still high", stall, 1);
      wait_free();
      for (int i = 0; i < N_IN; i++)
         chk("R3 first read-in", acc_in[32*i +: 32], gen(IN1 + 32'(4*i)));
      rd_idx = N_IN;
      do_read_in("R8 ignored command consumed nothing");
   endtask

   task automatic t_idle_prefetch();
      ack_dly = 1;
      repeat (40) @(negedge clk);
      for (int r = 0; r < 4; r++) do_read_in("R11 stream intact after idle prefetch");
   endtask

   task automatic t_write_flush();
      int bad = 0;
      ack_dly = 2;
      wlog_n = 0;
      for (int r = 0; r < 3; r++) do_write_out();
      do_flush();
      for (int i = 0; i < 6; i++) if (wmem[i] !== out_val(i)) bad++;
      chk("R5 captured words in port order", bad, 0);
      chk("R6 beat count", wlog_n, 2);
      chk("R6 full beat selects", wsel_log[0], 16'hFFFF);
      chk("R6 first write address", wadr_log[0], OUT1);
      chk("R7 partial beat selects", wsel_log[1], 16'h00FF);
      chk("R7 partial beat address", wadr_log[1], OUT1 + 32'd16);
      chk("R7 unselected words untouched", wmem[6], 0);
   endtask

   task automatic t_overlap();
      int bad = 0;
      for (int d = 0; d < 4; d++) begin
         ack_dly = d;
         for (int r = 0; r < 3; r++) begin
            do_write_out();
            do_read_in("R3 read-in during write traffic");
         end
      end
      do_write_out();
      do_flush();
      for (int k = 6; k < wk; k++) if (wmem[8 + k - 6] !== out_val(k)) bad++;
      chk("R6 memory image under overlapping traffic", bad, 0);
      chk("R7 flushed tail present", wmem[8 + wk - 7], out_val(wk - 1));
   endtask

   task automatic t_reload();
      int k0;
      ack_dly = 1;
      do_load(IN2, OUT2);
      do_read_in("R10 read-in after reload");
      k0 = wk;
      do_write_out();
      do_flush();
      chk("R10 write at new destination", wmem[(OUT2 - OUT1) >> 2], out_val(k0));
      chk("R10 second word at new destination", wmem[((OUT2 - OUT1) >> 2) + 1], out_val(k0 + 1));
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 0;
      t_reset();
      t_read_start();
      t_idle_prefetch();
      t_write_flush();
      t_overlap();
      t_reload();
      chk("R2 read addresses sequential", radr_err, 0);
      chk("R9 request held until acknowledge", hold_err, 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule